// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes as asynchronous serial frames on a single output line. The transmitter has two storage stages: a holding register that software fills, and a shift register that drives the line. Software writes a byte into the holding register. The same write clears a data-empty flag. On the next bit tick the transmitter copies the byte into the shift register, sets the data-empty flag again and starts the frame. Software can therefore queue the following byte while the current one is still being shifted out.

A frame is a start bit of 0, then 7 or 8 data bits sent least significant bit first, then an optional extra bit, then one or two stop bits of 1. The extra bit can be even parity, odd parity or a multiprocessor marker bit, or it can be left out. The transmitter looks at the data-empty flag on the tick that ends the last stop bit. If a byte is waiting, its start bit follows at once. If no byte is waiting, the transmitter sets a transmit-end flag and holds the line at 1. Each flag drives a level interrupt request that has its own enable input.

An external one-cycle baud tick sets the bit time. One bit lasts from one tick to the next.

Top module: `async_tx_core`

## Requirements
- R1: After reset, `txd_o` is 1, `empty_flag_o` is 1 and `end_flag_o` is 1. With both enables at 0, neither interrupt output is asserted.
- R2: A pulse on `wr_en_i` while `empty_flag_o` is 1 stores `wr_data_i` and clears both `empty_flag_o` and `end_flag_o` on the next edge. A pulse on `wr_en_i` while `empty_flag_o` is 0 is ignored: the byte that was stored earlier is the one sent.
- R3: When the transmitter is idle with `empty_flag_o` at 0, the next `baud_tick_i` copies the stored byte, sets `empty_flag_o` to 1 and drives the start bit of 0. `txd_o` changes only on a clock edge where `baud_tick_i` is 1, so each bit lasts exactly one tick period.
- R4: A frame is sent in this order: a start bit of 0, the data bits least significant bit first, the optional extra bit, then the stop bits of 1. With `fmt_short_i` at 1 the frame has 7 data bits (bits 6..0) and bit 7 is not sent. With `fmt_short_i` at 0 the frame has 8 data bits.
- R5: `fmt_xbit_i` selects the extra bit:
  - 2'b00: no extra bit.
  - 2'b01: even parity, so the data bits sent plus the parity bit hold an even number of ones.
  - 2'b10: odd parity.
  - 2'b11: the multiprocessor bit, which takes the value of `mpb_i`.
- R6: The frame format inputs and `mpb_i` are sampled when the byte is copied into the shift register. Changing them later does not alter the frame in progress.
- R7: With `fmt_two_stop_i` at 1 the frame ends with two stop bits of 1. With it at 0 the frame ends with one stop bit.
- R8: If `empty_flag_o` is 0 on the tick that ends the last stop bit, the start bit of the waiting byte begins on that same tick, with no idle bit between the frames, and `end_flag_o` stays 0.
- R9: If `empty_flag_o` is 1 on the tick that ends the last stop bit, `end_flag_o` becomes 1 and `txd_o` stays at 1 until a later frame starts.
- R10: `empty_irq_o` equals `empty_flag_o` AND `empty_ie_i`. `end_irq_o` equals `end_flag_o` AND `end_ie_i`. Both are level signals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse that marks each bit boundary |
| wr_en_i | input | 1 | Write strobe for the holding register; clears the data-empty flag |
| wr_data_i | input | 8 | Byte written into the holding register |
| fmt_short_i | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| fmt_xbit_i | input | 2 | Extra bit: 00 none, 01 even parity, 10 odd parity, 11 multiprocessor bit |
| fmt_two_stop_i | input | 1 | 1 = two stop bits, 0 = one stop bit |
| mpb_i | input | 1 | Value of the multiprocessor bit |
| empty_ie_i | input | 1 | Enable for the data-empty interrupt |
| end_ie_i | input | 1 | Enable for the transmit-end interrupt |
| txd_o | output | 1 | Serial output line; idles at 1 |
| empty_flag_o | output | 1 | Data-empty flag: the holding register can take a byte |
| end_flag_o | output | 1 | Transmit-end flag: the line is idle and no byte is waiting |
| empty_irq_o | output | 1 | Data-empty interrupt request |
| end_irq_o | output | 1 | Transmit-end interrupt request |

## Verification
The hardest case to reach from the ports is a chained frame. The second byte must be written after the first byte leaves the holding register but before the tick that ends the first frame's stop bit. Only then is the start bit shown to follow the stop bit with no idle bit. The bench reaches this case because it drives every tick itself. It writes the second byte straight after the loading tick, then walks the first frame bit by bit, and checks that the tick ending the stop bit produces a 0 and leaves the transmit-end flag clear. Two other tests also depend on that control of the ticks. The ignored-write test writes a second byte before the loading tick. The format-sampling test changes the format inputs one tick after the load.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

   // Selects the bit that goes after the data bits
   typedef enum logic [1:0] {
      XB_NONE = 2'b00,
      XB_EVEN = 2'b01,
      XB_ODD  = 2'b10,
      XB_MARK = 2'b11
   } xbit_e;

   // Bit position within the frame
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_XBIT,
      ST_STOP
   } txst_e;

endpackage

// File: rtl/async_tx_holdreg.sv
module async_tx_holdreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              load_i,
   input  logic              done_i,
   output logic [DATA_W-1:0] hold_o,
   output logic              empty_o,
   output logic              end_o
);

   logic [DATA_W-1:0] hold_q;
   logic              empty_q;
   logic              end_q;
   logic              accept;

   // A write is taken only while the holding register is free
   assign accept = wr_en_i & empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         empty_q <= 1'b1;
         end_q   <= 1'b1;
      end else begin
         if (accept) begin
            hold_q  <= wr_data_i;
            empty_q <= 1'b0;
         end else if (load_i) begin
            empty_q <= 1'b1;
         end
         // A new write takes priority over the end of a frame
         if (accept) begin
            end_q <= 1'b0;
         end else if (done_i) begin
            end_q <= 1'b1;
         end
      end
   end

   assign hold_o  = hold_q;
   assign empty_o = empty_q;
   assign end_o   = end_q;

   // R2: a write while the holding register is full leaves it unchanged
   a_r2_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !empty_q) |=> $stable(hold_q));

   // R3: copying into the shift register frees the holding register
   a_r3_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> empty_q);

endmodule

// File: rtl/async_tx_parity.sv
module async_tx_parity
   import async_tx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SHORT_W = 7
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              short_i,
   input  logic [1:0]        mode_i,
   input  logic              mpb_i,
   output logic              xbit_o,
   output logic              has_x_o
);

   logic [DATA_W-1:0] used;
   logic              ones_odd;

   // Keep only the bits that the frame will carry
   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      if (i < SHORT_W) begin : g_always
         assign used[i] = data_i[i];
      end else begin : g_long_only
         assign used[i] = data_i[i] & ~short_i;
      end
   end

   assign ones_odd = ^used;

   always_comb begin
      has_x_o = 1'b1;
      unique case (xbit_e'(mode_i))
         XB_NONE: begin
            xbit_o  = 1'b0;
            has_x_o = 1'b0;
         end
         XB_EVEN: xbit_o = ones_odd;
         XB_ODD:  xbit_o = ~ones_odd;
         XB_MARK: xbit_o = mpb_i;
         default: xbit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/async_tx_framer.sv
module async_tx_framer
   import async_tx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SHORT_W = 7,
   localparam int CNT_W  = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              pend_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              short_i,
   input  logic              two_stop_i,
   input  logic              xbit_i,
   input  logic              has_x_i,
   output logic              load_o,
   output logic              done_o,
   output logic              txd_o
);

   txst_e             st_q;
   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  nbits_q;
   logic              xbit_q;
   logic              has_x_q;
   logic              two_q;
   logic              last_stop;
   logic              last_data;

   assign last_stop = (st_q == ST_STOP) && (two_q ? (cnt_q == CNT_W'(1)) : 1'b1);
   assign last_data = (cnt_q == nbits_q - CNT_W'(1));

   // The waiting byte is taken when idle or at the end of the last stop bit
   assign load_o = tick_i & pend_i & ((st_q == ST_IDLE) | last_stop);
   assign done_o = tick_i & last_stop & ~pend_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         sh_q    <= '0;
         cnt_q   <= '0;
         nbits_q <= CNT_W'(DATA_W);
         xbit_q  <= 1'b0;
         has_x_q <= 1'b0;
         two_q   <= 1'b0;
      end else if (tick_i) begin
         if (load_o) begin
            sh_q    <= data_i;
            nbits_q <= short_i ? CNT_W'(SHORT_W) : CNT_W'(DATA_W);
            xbit_q  <= xbit_i;
            has_x_q <= has_x_i;
            two_q   <= two_stop_i;
            cnt_q   <= '0;
            st_q    <= ST_START;
         end else begin
            unique case (st_q)
               ST_IDLE: st_q <= ST_IDLE;
               ST_START: begin
                  cnt_q <= '0;
                  st_q  <= ST_DATA;
               end
               ST_DATA: begin
                  sh_q <= sh_q >> 1;
                  if (last_data) begin
                     cnt_q <= '0;
                     st_q  <= has_x_q ? ST_XBIT : ST_STOP;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               ST_XBIT: begin
                  cnt_q <= '0;
                  st_q  <= ST_STOP;
               end
               ST_STOP: begin
                  if (last_stop) begin
                     st_q <= ST_IDLE;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      unique case (st_q)
         ST_START: txd_o = 1'b0;
         ST_DATA:  txd_o = sh_q[0];
         ST_XBIT:  txd_o = xbit_q;
         default:  txd_o = 1'b1;
      endcase
   end

   // R3, R8: each load is followed by a start bit
   a_r3_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> (txd_o == 1'b0));

   // R3: without a tick the line holds its value
   a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(txd_o));

endmodule

// File: rtl/async_tx_core.sv
module async_tx_core #(
   parameter int DATA_W  = 8,
   parameter int SHORT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              fmt_short_i,
   input  logic [1:0]        fmt_xbit_i,
   input  logic              fmt_two_stop_i,
   input  logic              mpb_i,
   input  logic              empty_ie_i,
   input  logic              end_ie_i,
   output logic              txd_o,
   output logic              empty_flag_o,
   output logic              end_flag_o,
   output logic              empty_irq_o,
   output logic              end_irq_o
);

   if (DATA_W < 2) begin : g_bad_width
      $error("async_tx_core: DATA_W must be at least 2");
   end
   if (SHORT_W < 1 || SHORT_W >= DATA_W) begin : g_bad_short
      $error("async_tx_core: SHORT_W must be in 1..DATA_W-1");
   end

   logic [DATA_W-1:0] hold;
   logic              load;
   logic              done;
   logic              xbit;
   logic              has_x;

   async_tx_holdreg #(.DATA_W(DATA_W)) i_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .load_i    (load),
      .done_i    (done),
      .hold_o    (hold),
      .empty_o   (empty_flag_o),
      .end_o     (end_flag_o)
   );

   async_tx_parity #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) i_par (
      .data_i  (hold),
      .short_i (fmt_short_i),
      .mode_i  (fmt_xbit_i),
      .mpb_i   (mpb_i),
      .xbit_o  (xbit),
      .has_x_o (has_x)
   );

   async_tx_framer #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) i_frm (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (baud_tick_i),
      .pend_i     (~empty_flag_o),
      .data_i     (hold),
      .short_i    (fmt_short_i),
      .two_stop_i (fmt_two_stop_i),
      .xbit_i     (xbit),
      .has_x_i    (has_x),
      .load_o     (load),
      .done_o     (done),
      .txd_o      (txd_o)
   );

   assign empty_irq_o = empty_flag_o & empty_ie_i;
   assign end_irq_o   = end_flag_o & end_ie_i;

   // R9: once transmission has ended the line is in the mark state
   a_r9_end_means_mark: assert property (@(posedge clk) disable iff (!rst_n)
      end_flag_o |-> txd_o);

endmodule

// File: tb/test_async_tx_core.sv
module test_async_tx_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       f_short = 1'b0;
   logic [1:0] f_xbit = 2'b00;
   logic       f_two = 1'b0;
   logic       mpb = 1'b0;
   logic       e_ie = 1'b0;
   logic       t_ie = 1'b0;
   logic       txd, eflag, tflag, eirq, tirq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   bit exp_bits [0:12];
   int exp_len;

   always #10 clk = ~clk;   // 50 MHz

   async_tx_core i_async_tx_core (
      .clk(clk), .rst_n(rst_n), .baud_tick_i(tick),
      .wr_en_i(wr_en), .wr_data_i(wr_data),
      .fmt_short_i(f_short), .fmt_xbit_i(f_xbit), .fmt_two_stop_i(f_two),
      .mpb_i(mpb), .empty_ie_i(e_ie), .end_ie_i(t_ie),
      .txd_o(txd), .empty_flag_o(eflag), .end_flag_o(tflag),
      .empty_irq_o(eirq), .end_irq_o(tirq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Expected frame from the requirements
   function automatic void fill(input logic [7:0] d, input bit s7,
                                input logic [1:0] m, input bit two, input bit mp);
      int n = s7 ? 7 : 8;
      bit ones = 1'b0;
      exp_len = 0;
      exp_bits[exp_len++] = 1'b0;
      for (int i = 0; i < n; i++) begin
         exp_bits[exp_len++] = d[i];
         ones ^= d[i];
      end
      if (m == 2'b01) exp_bits[exp_len++] = ones;
      if (m == 2'b10) exp_bits[exp_len++] = ~ones;
      if (m == 2'b11) exp_bits[exp_len++] = mp;
      exp_bits[exp_len++] = 1'b1;
      if (two) exp_bits[exp_len++] = 1'b1;
   endfunction

   task automatic write_byte(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic do_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic run_frame(input logic [7:0] d, input bit s7, input logic [1:0] m,
                            input bit two, input bit mp, input bit disturb,
                            input bit dup, input string req);
      f_short = s7; f_xbit = m; f_two = two; mpb = mp;
      fill(d, s7, m, two, mp);
      write_byte(d);
      check({req, " R2 empty cleared"}, eflag, 0);
      if (dup) write_byte(~d);   // R2: ignored while full
      for (int i = 0; i < exp_len; i++) begin
         do_tick();
         if (i == 0) begin
            check({req, " R3 empty set on load"}, eflag, 1);
            if (disturb) begin   // R6: change format after load
               f_short = ~s7; f_xbit = ~m; f_two = ~two; mpb = ~mp;
            end
         end
         check($sformatf("%s R4 bit %0d", req, i), txd, exp_bits[i]);
      end
      do_tick();
      check({req, " R9 line idle"}, txd, 1);
      check({req, " R9 end flag"}, tflag, 1);
   endtask

   task automatic t_reset();
      check("R1 txd", txd, 1);
      check("R1 empty", eflag, 1);
      check("R1 end", tflag, 1);
      check("R1 irqs", {eirq, tirq}, 0);
      do_tick();
      check("R3 idle tick keeps mark", txd, 1);
   endtask

   task automatic t_formats();
      run_frame(8'hA5, 0, 2'b00, 0, 0, 0, 0, "R4 8N1");
      run_frame(8'hD3, 1, 2'b01, 1, 0, 0, 0, "R5 R7 7E2");
      run_frame(8'h0F, 0, 2'b10, 0, 0, 0, 0, "R5 8O1");
      run_frame(8'h80, 0, 2'b01, 0, 0, 0, 0, "R5 8E1");
      run_frame(8'h00, 0, 2'b11, 0, 1, 0, 0, "R5 mpb");
   endtask

   task automatic t_sampled();
      run_frame(8'h6B, 0, 2'b11, 1, 1, 1, 0, "R6 sampled");
   endtask

   task automatic t_ignore();
      run_frame(8'h3C, 0, 2'b00, 0, 0, 0, 1, "R2 ignore");
   endtask

   task automatic t_notick();
      f_short = 0; f_xbit = 2'b00; f_two = 0;
      write_byte(8'h01);
      do_tick();
      repeat (6) @(negedge clk);
      check("R3 start held without tick", txd, 0);
      do_tick();
      check("R3 first data bit", txd, 1);
      for (int i = 0; i < 9; i++) do_tick();
      check("R9 idle after frame", txd, 1);
   endtask

   task automatic t_b2b();
      f_short = 0; f_xbit = 2'b01; f_two = 1; mpb = 0;
      fill(8'h96, 0, 2'b01, 1, 0);
      write_byte(8'h96);
      do_tick();
      check("R8 first start", txd, 0);
      write_byte(8'h4E);
      check("R8 second queued", eflag, 0);
      for (int i = 1; i < exp_len; i++) begin
         do_tick();
         check($sformatf("R8 first frame bit %0d", i), txd, exp_bits[i]);
      end
      fill(8'h4E, 0, 2'b01, 1, 0);
      do_tick();
      check("R8 start follows stop", txd, 0);
      check("R8 end flag stays clear", tflag, 0);
      check("R8 second byte loaded", eflag, 1);
      for (int i = 1; i < exp_len; i++) begin
         do_tick();
         check($sformatf("R8 second frame bit %0d", i), txd, exp_bits[i]);
      end
      do_tick();
      check("R9 end after chain", tflag, 1);
   endtask

   task automatic t_irq();
      f_short = 0; f_xbit = 2'b00; f_two = 0;
      e_ie = 1; t_ie = 1;
      @(negedge clk);
      check("R10 both irqs at idle", {eirq, tirq}, 3);
      write_byte(8'h55);
      check("R10 irqs after write", {eirq, tirq}, 0);
      do_tick();
      check("R10 empty irq after load", {eirq, tirq}, 2);
      for (int i = 0; i < 10; i++) do_tick();
      check("R10 end irq after frame", {eirq, tirq}, 3);
      e_ie = 0;
      @(negedge clk);
      check("R10 empty irq masked", {eirq, tirq}, 1);
      t_ie = 0;
      @(negedge clk);
      check("R10 end irq masked", {eirq, tirq}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_formats();
      t_sampled();
      t_ignore();
      t_notick();
      t_b2b();
      t_irq();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule